// File: doc/BRIEF.md
# Periodic Frame Bandwidth Allocator

This block keeps a byte-time budget for each of 32 recurring frame slots. Together these slots form the periodic schedule of a full-speed bus. The low five bits of the running frame number pick a slot, so each slot comes round again every 32 frames. A client asks the engine to reserve or return bus time for a periodic endpoint. The request gives a cost in byte-times, a polling interval given as its base-two logarithm (0 to 5, which is 1 to 32 frames), and, for a return, the phase that was granted earlier.

For a reservation, the engine first scans all 32 slots for the lightest one. If even that slot cannot absorb the cost under the periodic ceiling of 1293 byte-times, the request is rejected at once. Otherwise the engine scores every candidate phase by the heaviest slot that phase would touch, and picks the phase with the lowest score. It re-checks that score against the ceiling. Then it either adds the cost to every slot at phase, phase+N, phase+2N and so on, or it rejects the request and changes nothing. A return subtracts the cost from the same strided slots, stopping at zero. The scan and the update step through one slot per clock cycle. A read port shows the reserved load of any slot, for example the slot of the current frame.

Top module: `pfb_alloc`

## Requirements
- R1: After synchronous reset every slot load reads 0, and busy and done are low.
- R2: An accepted reservation with interval code L (N = 2^L) and granted phase p adds the cost to exactly the slots p + k*N for k = 0 .. 32/N-1. Every other slot is left as it was, and no slot load ever exceeds 1293.
- R3: The granted phase, reported on rsp_phase, is the phase among 0 .. N-1 whose heaviest targeted slot is the lightest. On a tie, the lowest phase wins.
- R4: A reservation whose cost, added to the lightest of all 32 slots, exceeds 1293 is rejected: err is high with done, rsp_phase is 0, and no slot changes.
- R5: A reservation whose cost, added to the heaviest slot of the best phase, exceeds 1293 is rejected with no slot changed. A sum of exactly 1293 is accepted.
- R6: A release (req_release = 1) uses phase req_phase mod N, subtracts the cost from those strided slots and clamps each at 0. It reports that phase with err low.
- R7: An interval code above 5 is rejected with err high and rsp_phase 0, and no slot changes.
- R8: busy is high from the cycle after a request is accepted until the response. A request presented while busy is high, including in the cycle done is high, is ignored: it produces no response and no change to any slot.
- R9: Each accepted request produces exactly one done pulse, one cycle long. err is only ever high together with done.
- R10: frame_load shows the current load of the slot selected by frame_idx, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_release | input | 1 | 0 = reserve, 1 = release |
| req_cost | input | 11 | Cost in byte-times |
| req_ilog | input | 3 | Polling interval as log2 of frames (0..5 valid) |
| req_phase | input | 5 | Phase to release (ignored for reserve) |
| busy | output | 1 | Engine is processing a request |
| done | output | 1 | One-cycle response strobe |
| err | output | 1 | Request rejected (valid with done) |
| rsp_phase | output | 5 | Granted or released phase |
| frame_idx | input | 5 | Slot to observe |
| frame_load | output | 11 | Reserved load of the observed slot |

## Verification
The collision that matters is a new request strobe landing on the cycle in which the engine is scanning, or on the cycle it raises done for the previous request. The bench provokes both cases: it pulses req_valid with a different, harmful request three cycles into a reservation scan, and again on the exact cycle done is seen high. It judges each case by counting responses in the scoreboard, so that a stray done shows up as an unexpected item. It also reads back all 32 slot loads against an independent model. The model also computes the expected phase choices, tie breaks, clamped releases and the exact-fit boundary.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MIN    = 3'd1,
        ST_PHASE  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_RESP   = 3'd4
    } pfb_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } pfb_op_e;

    // Budget test shared by the early and the final check.
    function automatic logic fits(input int unsigned load,
                                  input int unsigned cost,
                                  input int unsigned limit);
        return (load + cost) <= limit;
    endfunction

endpackage

// File: rtl/pfb_frame_bank.sv
module pfb_frame_bank
    import pfb_pkg::*;
#(
    parameter int FR_LG  = 5,
    parameter int LOAD_W = 11,
    parameter int LIMIT  = 1293
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FR_LG-1:0]  scan_idx,
    output logic [LOAD_W-1:0] scan_load,
    input  logic              we,
    input  pfb_op_e           op,
    input  logic [LOAD_W-1:0] amount,
    input  logic [FR_LG-1:0]  peek_idx,
    output logic [LOAD_W-1:0] peek_load
);
    localparam int NF = 1 << FR_LG;

    logic [LOAD_W-1:0] load_q [NF];
    logic [LOAD_W:0]   sum;
    logic [LOAD_W-1:0] upd;

    assign scan_load = load_q[scan_idx];
    assign peek_load = load_q[peek_idx];

    always_comb begin
        sum = {1'b0, scan_load} + {1'b0, amount};
        if (op == OP_ADD)
            upd = sum[LOAD_W-1:0];
        else if (scan_load > amount)
            upd = scan_load - amount;
        else
            upd = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NF; i++) load_q[i] <= '0;
        end else if (we) begin
            load_q[scan_idx] <= upd;
        end
    end

    // R5
    commit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_ADD) |-> (sum <= LIMIT));

endmodule

// File: rtl/pfb_phase_scan.sv
module pfb_phase_scan #(
    parameter int FR_LG  = 5,
    parameter int LOAD_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              min_en,
    input  logic              first,
    input  logic              grp_en,
    input  logic              grp_first,
    input  logic              grp_last,
    input  logic [FR_LG-1:0]  grp_phase,
    input  logic [LOAD_W-1:0] load_in,
    output logic [LOAD_W-1:0] min_nxt,
    output logic [LOAD_W-1:0] best_max_nxt,
    output logic [FR_LG-1:0]  best_phase_nxt
);
    logic [LOAD_W-1:0] min_q, gmax_q, best_max_q, gmax_nxt;
    logic [FR_LG-1:0]  best_phase_q;

    always_comb begin
        min_nxt  = (first || load_in < min_q) ? load_in : min_q;
        gmax_nxt = (grp_first || load_in > gmax_q) ? load_in : gmax_q;
        best_max_nxt   = best_max_q;
        best_phase_nxt = best_phase_q;
        // Strict comparison keeps the lower phase on equal scores.
        if (grp_last && (grp_phase == '0 || gmax_nxt < best_max_q)) begin
            best_max_nxt   = gmax_nxt;
            best_phase_nxt = grp_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q        <= '0;
            gmax_q       <= '0;
            best_max_q   <= '0;
            best_phase_q <= '0;
        end else begin
            if (min_en) min_q <= min_nxt;
            if (grp_en) begin
                gmax_q       <= gmax_nxt;
                best_max_q   <= best_max_nxt;
                best_phase_q <= best_phase_nxt;
            end
        end
    end

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
    import pfb_pkg::*;
#(
    parameter int FR_LG   = 5,
    parameter int LOAD_W  = 11,
    parameter int LIMIT   = 1293,
    parameter int ILOG_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_release,
    input  logic [LOAD_W-1:0] req_cost,
    input  logic [ILOG_W-1:0] req_ilog,
    input  logic [FR_LG-1:0]  req_phase,
    input  logic [LOAD_W-1:0] min_nxt,
    input  logic [LOAD_W-1:0] best_max_nxt,
    input  logic [FR_LG-1:0]  best_phase_nxt,
    output logic [FR_LG-1:0]  scan_idx,
    output logic              we,
    output pfb_op_e           op,
    output logic [LOAD_W-1:0] amount,
    output logic              min_en,
    output logic              first,
    output logic              grp_en,
    output logic              grp_first,
    output logic              grp_last,
    output logic [FR_LG-1:0]  grp_phase,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [FR_LG-1:0]  rsp_phase
);
    pfb_state_e        state_q;
    logic [FR_LG-1:0]  cnt_q, phase_q, kmask, kpos;
    logic [LOAD_W-1:0] cost_q;
    logic [ILOG_W-1:0] ilog_q;
    logic              release_q, err_q;
    int unsigned       glg;

    // Slots per phase group is 2^glg; kpos is the position within a group.
    always_comb begin
        glg       = (int'(ilog_q) <= FR_LG) ? FR_LG - int'(ilog_q) : 0;
        kmask     = FR_LG'((32'd1 << glg) - 32'd1);
        kpos      = cnt_q & kmask;
        grp_phase = FR_LG'(cnt_q >> glg);
        min_en    = (state_q == ST_MIN);
        grp_en    = (state_q == ST_PHASE);
        we        = (state_q == ST_COMMIT);
        first     = min_en && (cnt_q == '0);
        grp_first = grp_en && (kpos == '0);
        grp_last  = grp_en && (kpos == kmask);
        op        = release_q ? OP_SUB : OP_ADD;
        amount    = cost_q;
        case (state_q)
            ST_PHASE:  scan_idx = grp_phase + FR_LG'(kpos << ilog_q);
            ST_COMMIT: scan_idx = phase_q + FR_LG'(cnt_q << ilog_q);
            default:   scan_idx = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            cost_q    <= '0;
            ilog_q    <= '0;
            phase_q   <= '0;
            release_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    cost_q    <= req_cost;
                    ilog_q    <= req_ilog;
                    release_q <= req_release;
                    cnt_q     <= '0;
                    err_q     <= 1'b0;
                    phase_q   <= '0;
                    if (int'(req_ilog) > FR_LG) begin
                        err_q   <= 1'b1;
                        state_q <= ST_RESP;
                    end else if (req_release) begin
                        phase_q <= req_phase & FR_LG'((32'd1 << req_ilog) - 32'd1);
                        state_q <= ST_COMMIT;
                    end else begin
                        state_q <= ST_MIN;
                    end
                end
                ST_MIN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '1) begin
                        if (!fits(32'(min_nxt), 32'(cost_q), LIMIT)) begin
                            err_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_PHASE;
                        end
                    end
                end
                ST_PHASE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '1) begin
                        if (!fits(32'(best_max_nxt), 32'(cost_q), LIMIT)) begin
                            err_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end else begin
                            phase_q <= best_phase_nxt;
                            state_q <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == kmask) begin
                        cnt_q   <= '0;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_RESP);
    assign err       = done && err_q;
    assign rsp_phase = phase_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R7
    commit_ilog_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(ilog_q) <= FR_LG));

endmodule

// File: rtl/pfb_alloc.sv
module pfb_alloc
    import pfb_pkg::*;
#(
    parameter int FR_LG  = 5,
    parameter int LOAD_W = 11,
    parameter int LIMIT  = 1293,
    parameter int ILOG_W = $clog2(FR_LG + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_release,
    input  logic [LOAD_W-1:0] req_cost,
    input  logic [ILOG_W-1:0] req_ilog,
    input  logic [FR_LG-1:0]  req_phase,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [FR_LG-1:0]  rsp_phase,
    input  logic [FR_LG-1:0]  frame_idx,
    output logic [LOAD_W-1:0] frame_load
);
    logic [FR_LG-1:0]  scan_idx, grp_phase, best_phase_nxt;
    logic [LOAD_W-1:0] scan_load, amount, min_nxt, best_max_nxt;
    logic              we, min_en, first, grp_en, grp_first, grp_last;
    pfb_op_e           op;

    pfb_ctrl #(.FR_LG(FR_LG), .LOAD_W(LOAD_W), .LIMIT(LIMIT), .ILOG_W(ILOG_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_release(req_release), .req_cost(req_cost),
        .req_ilog(req_ilog), .req_phase(req_phase),
        .min_nxt(min_nxt), .best_max_nxt(best_max_nxt), .best_phase_nxt(best_phase_nxt),
        .scan_idx(scan_idx), .we(we), .op(op), .amount(amount),
        .min_en(min_en), .first(first), .grp_en(grp_en), .grp_first(grp_first),
        .grp_last(grp_last), .grp_phase(grp_phase),
        .busy(busy), .done(done), .err(err), .rsp_phase(rsp_phase)
    );

    pfb_phase_scan #(.FR_LG(FR_LG), .LOAD_W(LOAD_W)) scan_i (
        .clk(clk), .rst(rst),
        .min_en(min_en), .first(first), .grp_en(grp_en), .grp_first(grp_first),
        .grp_last(grp_last), .grp_phase(grp_phase), .load_in(scan_load),
        .min_nxt(min_nxt), .best_max_nxt(best_max_nxt), .best_phase_nxt(best_phase_nxt)
    );

    pfb_frame_bank #(.FR_LG(FR_LG), .LOAD_W(LOAD_W), .LIMIT(LIMIT)) bank_i (
        .clk(clk), .rst(rst),
        .scan_idx(scan_idx), .scan_load(scan_load),
        .we(we), .op(op), .amount(amount),
        .peek_idx(frame_idx), .peek_load(frame_load)
    );

    // R2
    frame_cap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_load <= LIMIT);

endmodule

// File: tb/pfb_alloc_tb_top.sv
module pfb_alloc_tb_top;
    localparam int FR_LG = 5;
    localparam int NF    = 32;
    localparam int LIMIT = 1293;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_release = 1'b0;
    logic [10:0] req_cost  = '0;
    logic [2:0]  req_ilog  = '0;
    logic [4:0]  req_phase = '0, frame_idx = '0;
    logic        busy, done, err;
    logic [4:0]  rsp_phase;
    logic [10:0] frame_load;

    always #5 clk = ~clk;

    pfb_alloc dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_release(req_release),
        .req_cost(req_cost), .req_ilog(req_ilog), .req_phase(req_phase),
        .busy(busy), .done(done), .err(err), .rsp_phase(rsp_phase),
        .frame_idx(frame_idx), .frame_load(frame_load)
    );

    typedef struct { bit err; int phase; string tag; } exp_t;
    exp_t q[$];
    exp_t got;
    int   model[NF];
    int   n_tests = 0, n_fail = 0;
    bit   prev_done = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every response.
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) chk("R9 done wider than one cycle", 1, 0);
            if (err && !done) chk("R9 err without done", 1, 0);
            if (done) begin
                if (q.size() == 0) chk("R8 unexpected response", 1, 0);
                else begin
                    got = q.pop_front();
                    chk({got.tag, " err"}, int'(err), int'(got.err));
                    chk({got.tag, " phase"}, int'(rsp_phase), got.phase);
                end
            end
        end
        prev_done = done;
    end

    // Driver: computes the expectation, updates the model, strobes the request.
    task automatic issue(bit rel, int cost, int ilog, int phase, string tag);
        exp_t e;
        int n, mn, bm, bp, gm;
        e.tag = tag; e.err = 1'b0; e.phase = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        if (ilog > FR_LG) e.err = 1'b1;
        else begin
            n = 1 << ilog;
            if (rel) begin
                e.phase = phase & (n - 1);
                for (int f = e.phase; f < NF; f += n)
                    model[f] = (model[f] > cost) ? model[f] - cost : 0;
            end else begin
                mn = model[0];
                for (int f = 1; f < NF; f++) if (model[f] < mn) mn = model[f];
                if (mn + cost > LIMIT) e.err = 1'b1;
                else begin
                    bp = -1; bm = 0;
                    for (int p = 0; p < n; p++) begin
                        gm = 0;
                        for (int f = p; f < NF; f += n) if (model[f] > gm) gm = model[f];
                        if (bp < 0 || gm < bm) begin bp = p; bm = gm; end
                    end
                    if (bm + cost > LIMIT) e.err = 1'b1;
                    else begin
                        e.phase = bp;
                        for (int f = bp; f < NF; f += n) model[f] += cost;
                    end
                end
            end
        end
        q.push_back(e);
        req_release = rel; req_cost = 11'(cost); req_ilog = 3'(ilog);
        req_phase = 5'(phase); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic check_loads(string tag);
        for (int f = 0; f < NF; f++) begin
            frame_idx = 5'(f);
            #1;
            chk($sformatf("%s slot %0d", tag, f), int'(frame_load), model[f]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int mx;
        for (int f = 0; f < NF; f++) model[f] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        check_loads("R1 reset load");

        // R2 R3 all tie -> phase 0
        issue(0, 100, 2, 0, "R3 tie picks lowest"); wait_resp();
        check_loads("R2 stride 4");
        // R3 phase 0 now heavier -> phase 1
        issue(0, 50, 2, 0, "R3 lighter phase"); wait_resp();
        issue(0, 200, 0, 0, "R2 every slot"); wait_resp();
        issue(0, 30, 5, 0, "R3 single slot choice"); wait_resp();
        check_loads("R10 mixed loads");
        // R6 release with phase reduced modulo N, then clamped release
        issue(1, 50, 2, 5, "R6 release modulo"); wait_resp();
        issue(1, 1000, 5, 2, "R6 release clamp"); wait_resp();
        check_loads("R6 after release");
        // R7 bad interval code
        issue(0, 10, 6, 0, "R7 bad interval"); wait_resp();
        issue(1, 10, 7, 3, "R7 bad interval release"); wait_resp();
        check_loads("R7 unchanged");
        // R4 early reject
        issue(0, 1294, 5, 0, "R4 over least loaded"); wait_resp();
        check_loads("R4 unchanged");
        // R5 late reject, then exact fit
        issue(0, 1100, 0, 0, "R5 over worst slot"); wait_resp();
        check_loads("R5 unchanged");
        mx = 0;
        for (int f = 0; f < NF; f++) if (model[f] > mx) mx = model[f];
        issue(0, LIMIT - mx, 0, 0, "R5 exact fit"); wait_resp();
        check_loads("R5 exact fit load");
        issue(0, 1, 0, 0, "R5 one past full"); wait_resp();
        // R8 strobe during the scan
        issue(1, 300, 0, 0, "R8 release base"); wait_resp();
        issue(0, 40, 3, 0, "R8 scan target");
        repeat (2) @(negedge clk);
        chk("R8 busy during scan", int'(busy), 1);
        req_release = 1'b1; req_cost = 11'd2000; req_ilog = 3'd0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        wait_resp();
        repeat (80) @(negedge clk);
        chk("R8 no extra response", q.size(), 0);
        check_loads("R8 strobe while busy");
        // R8 strobe on the done cycle
        issue(0, 20, 1, 0, "R8 done-cycle target");
        while (!done) @(negedge clk);
        req_release = 1'b1; req_cost = 11'd2000; req_ilog = 3'd0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (80) @(negedge clk);
        chk("R8 done-cycle strobe ignored", q.size(), 0);
        check_loads("R8 done-cycle loads");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule